// File: doc/BRIEF.md
# Fair-share multichannel service arbiter

The block gathers service needs from a set of serial channels and raises them towards a host CPU. There are three kinds of need: receive, transmit and modem-signal change. Each kind has its own request output that all channels share, together with a channel-number output that tells the host which channel the request belongs to.

Each kind has its own scanner. The scanner visits the channels one per clock in ascending order and wraps around after the last one. When it reaches a channel whose need is raised, it posts that need. A posted request stays up until the host acknowledges it on that kind's acknowledge bit, and only then does the scanner move on.

Fairness is tracked separately for each kind. A channel that has been posted may not be posted again for that kind until every other channel with a pending need of that kind has had its turn. The channel count is a parameter with a default of 4.

Top module: `svc_fair_arb`

## Requirements
- R1: While reset is asserted and right after it, all three bits of `req_o` are 0 and every channel-number output is 0.
- R2: A need held on channel c of a kind is posted on that kind's `req_o` bit, and that kind's channel output carries c in binary. The bit index of a kind in `need`/`req_o`/`ack_i` is: 0 = receive, 1 = transmit, 2 = modem change.
- R3: While a request of a kind is posted and not acknowledged, that `req_o` bit stays 1 and its channel output does not change.
- R4: An acknowledge bit that is high at a clock edge while its request is posted clears that request, and the request reads 0 on the following cycle. An acknowledge bit given while its request is low has no effect.
- R5: After channel c is posted for a kind, c is not posted again for that kind until every other channel with a pending need of that kind has been posted.
- R6: After an acknowledge, scanning resumes at the channel after the one just granted. It advances one channel per clock in ascending order and wraps from NCH-1 to 0.
- R7: The three kinds work independently. They may post and be acknowledged in the same cycle without affecting one another.
- R8: A need that drops before the scanner reaches it is skipped and never posted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_need_i | input | NCH | Receive service need, one bit per channel |
| tx_need_i | input | NCH | Transmit service need, one bit per channel |
| mdm_need_i | input | NCH | Modem-signal-change need, one bit per channel |
| ack_i | input | 3 | Host acknowledge per kind (0 rx, 1 tx, 2 modem) |
| req_o | output | 3 | Posted request per kind (0 rx, 1 tx, 2 modem) |
| rx_chan_o | output | CW | Channel of the posted receive request |
| tx_chan_o | output | CW | Channel of the posted transmit request |
| mdm_chan_o | output | CW | Channel of the posted modem request |

## Verification
Two functions can fall in the same cycle: one kind being released by its acknowledge while another kind posts, and all three kinds posting at the same edge.

The bench provokes this by raising the same channel on all three kinds and acknowledging them together. After the common release, every scanner starts from the same pointer, so the next need common to all three must rise in one cycle on all three outputs. The rise cycles are stamped per kind and compared, and the per-kind scoreboards confirm that each kind still posts its own expected channel order.

// File: rtl/svc_arb_pkg.sv
package svc_arb_pkg;
  localparam int NKIND = 3;
  typedef enum logic [1:0] {
    KIND_RX  = 2'd0,
    KIND_TX  = 2'd1,
    KIND_MDM = 2'd2
  } svc_kind_e;
endpackage

// File: rtl/svc_fair_mask.sv
module svc_fair_mask #(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] need_i,
  input  logic [NCH-1:0] grant_i,
  output logic [NCH-1:0] served_o
);
  logic [NCH-1:0] served_q, served_nx;
  logic           round_done;

  always_comb begin
    served_nx  = served_q | grant_i;
    // round ends when no unserved channel is still pending
    round_done = ~|(need_i & ~served_nx);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         served_q <= '0;
    else if (round_done) served_q <= '0;
    else                 served_q <= served_nx;
  end

  assign served_o = served_q;
endmodule

// File: rtl/svc_type_scanner.sv
module svc_type_scanner #(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] need_i,
  input  logic           ack_i,
  output logic           req_o,
  output logic [CW-1:0]  chan_o
);
  logic [CW-1:0]  ptr_q, chan_q;
  logic           posted_q, hit;
  logic [NCH-1:0] grant, served;

  svc_fair_mask #(.NCH(NCH)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .need_i  (need_i),
    .grant_i (grant),
    .served_o(served)
  );

  always_comb begin
    hit   = !posted_q && need_i[ptr_q] && !served[ptr_q];
    grant = hit ? (NCH'(1) << ptr_q) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      chan_q   <= '0;
      posted_q <= 1'b0;
    end else begin
      if (!posted_q)
        ptr_q <= (ptr_q == CW'(NCH-1)) ? '0 : ptr_q + 1'b1;
      if (hit) begin
        posted_q <= 1'b1;
        chan_q   <= ptr_q;
      end else if (posted_q && ack_i) begin
        posted_q <= 1'b0;
      end
    end
  end

  assign req_o  = posted_q;
  assign chan_o = chan_q;

  AST_HOLD_POST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    posted_q && !ack_i |=> posted_q && $stable(chan_q)); // R3
  AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    posted_q && ack_i |=> !posted_q); // R4
  AST_POST_HAD_NEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(posted_q) |-> ($past(need_i) & (NCH'(1) << chan_q)) != '0); // R8
  AST_NO_EARLY_REPOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(posted_q) |-> ($past(served) & (NCH'(1) << chan_q)) == '0); // R5
endmodule

// File: rtl/svc_fair_arb.sv
module svc_fair_arb
  import svc_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   rx_need_i,
  input  logic [NCH-1:0]   tx_need_i,
  input  logic [NCH-1:0]   mdm_need_i,
  input  logic [NKIND-1:0] ack_i,
  output logic [NKIND-1:0] req_o,
  output logic [CW-1:0]    rx_chan_o,
  output logic [CW-1:0]    tx_chan_o,
  output logic [CW-1:0]    mdm_chan_o
);
  logic [NCH-1:0] need_k [NKIND];
  logic [CW-1:0]  chan_k [NKIND];

  assign need_k[KIND_RX]  = rx_need_i;
  assign need_k[KIND_TX]  = tx_need_i;
  assign need_k[KIND_MDM] = mdm_need_i;

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    svc_type_scanner #(.NCH(NCH)) u_scan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .need_i (need_k[k]),
      .ack_i  (ack_i[k]),
      .req_o  (req_o[k]),
      .chan_o (chan_k[k])
    );
  end

  assign rx_chan_o  = chan_k[KIND_RX];
  assign tx_chan_o  = chan_k[KIND_TX];
  assign mdm_chan_o = chan_k[KIND_MDM];

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> req_o == '0); // R1
endmodule

// File: tb/svc_fair_arb_bench.sv
module svc_fair_arb_bench;
  localparam int NCH = 4;
  localparam int CW  = 2;

  typedef struct {
    int    ch;
    string tag;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] rx_need = '0, tx_need = '0, mdm_need = '0;
  logic [2:0]     ack_man = '0, ack_auto = '0, ack, req;
  logic [CW-1:0]  rx_chan, tx_chan, mdm_chan;

  int checks = 0, failures = 0, cyc = 0;
  exp_t exp_q [3][$];
  int budget [3] = '{0, 0, 0};
  int cap [3], hold_cnt [3], rise_cyc [3];
  bit exp_drop [3] = '{0, 0, 0};
  logic [2:0] req_prev = '0;

  assign ack = ack_man | ack_auto;

  always #5 clk = ~clk;

  svc_fair_arb #(.NCH(NCH)) u_svc_fair_arb (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_need_i(rx_need), .tx_need_i(tx_need), .mdm_need_i(mdm_need),
    .ack_i(ack), .req_o(req),
    .rx_chan_o(rx_chan), .tx_chan_o(tx_chan), .mdm_chan_o(mdm_chan)
  );

  function automatic int chan_of(int t);
    case (t)
      0:       return int'(rx_chan);
      1:       return int'(tx_chan);
      default: return int'(mdm_chan);
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_post(int t, int ch, string tag);
    exp_t e;
    e.ch = ch;
    e.tag = tag;
    exp_q[t].push_back(e);
  endtask

  // monitor + auto acknowledger: one process so the edge order is fixed
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      ack_auto = '0;
      for (int t = 0; t < 3; t++) begin
        if (exp_drop[t]) begin
          check(req[t] == 1'b0, "R4 release after ack", int'(req[t]), 0);
          exp_drop[t] = 0;
        end
        if (rst_n && req[t] && !req_prev[t]) begin
          rise_cyc[t] = cyc;
          cap[t] = chan_of(t);
          hold_cnt[t] = 0;
          if (exp_q[t].size() == 0) begin
            check(0, "R5 unexpected post", chan_of(t), -1);
          end else begin
            exp_t e;
            e = exp_q[t].pop_front();
            check(chan_of(t) == e.ch, e.tag, chan_of(t), e.ch);
          end
        end
        if (req[t]) begin
          hold_cnt[t]++;
          if (hold_cnt[t] >= 3 && budget[t] > 0) begin
            check(chan_of(t) == cap[t], "R3 channel held", chan_of(t), cap[t]);
            budget[t]--;
            ack_auto[t] = 1'b1;
            exp_drop[t] = 1;
          end
        end
      end
      req_prev = req;
    end
  end

  task automatic ack_pulse(logic [2:0] m);
    @(negedge clk);
    ack_man = m;
    @(negedge clk);
    ack_man = '0;
    check((req & m) == '0, "R4 ack clears", int'(req & m), 0);
  endtask

  task automatic wait_settled(int t);
    while (!(req[t] && budget[t] == 0 && exp_q[t].size() == 0)) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req == '0 && rx_chan == '0 && tx_chan == '0 && mdm_chan == '0,
          "R1 reset state", int'(req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req == '0, "R1 after reset", int'(req), 0);

    // R4: acknowledge with nothing posted is ignored
    ack_pulse(3'b111);
    repeat (6) @(negedge clk);
    check(req == '0, "R4 idle ack ignored", int'(req), 0);

    // R2 / R6: pin the transmit pointer on ch1, then add ch2 and ch3
    tx_need = 4'b0010;
    expect_post(1, 1, "R2 first tx post");
    wait_settled(1);
    tx_need = 4'b1110;
    expect_post(1, 2, "R6 scan order ch2");
    expect_post(1, 3, "R6 scan order ch3");
    expect_post(1, 1, "R5 round wrap ch1");
    budget[1] = 3;
    wait_settled(1);
    tx_need = '0;
    ack_pulse(3'b010);
    repeat (2 * NCH) @(negedge clk);

    // R5: ch2 being serviced, ch3 pending, ch2 held
    tx_need = 4'b0100;
    expect_post(1, 2, "R2 tx ch2");
    wait_settled(1);
    tx_need = 4'b1100;
    expect_post(1, 3, "R5 ch3 before ch2 again");
    expect_post(1, 2, "R5 ch2 after ch3");
    budget[1] = 2;
    wait_settled(1);
    tx_need = '0;
    ack_pulse(3'b010);
    repeat (2 * NCH) @(negedge clk);

    // R8: receive ch1 pulses while ch0 is posted, then drops
    rx_need = 4'b0001;
    expect_post(0, 0, "R2 rx ch0");
    wait_settled(0);
    rx_need = 4'b0011;
    repeat (2) @(negedge clk);
    rx_need = 4'b1000;
    expect_post(0, 3, "R8 dropped ch1 skipped");
    budget[0] = 1;
    wait_settled(0);
    rx_need = '0;
    ack_pulse(3'b001);
    repeat (2 * NCH) @(negedge clk);

    // R7: all kinds together, shared ack, posts in the same cycle
    rx_need = 4'b0001;
    tx_need = 4'b0001;
    mdm_need = 4'b0001;
    for (int t = 0; t < 3; t++) expect_post(t, 0, "R7 all kinds ch0");
    wait_settled(0);
    wait_settled(1);
    wait_settled(2);
    rx_need = 4'b0101;
    tx_need = 4'b0101;
    mdm_need = 4'b0101;
    for (int t = 0; t < 3; t++) expect_post(t, 2, "R7 all kinds ch2");
    ack_pulse(3'b111);
    wait_settled(0);
    wait_settled(1);
    wait_settled(2);
    check(rise_cyc[0] == rise_cyc[1] && rise_cyc[1] == rise_cyc[2],
          "R7 same-cycle post", rise_cyc[0], rise_cyc[2]);
    for (int t = 0; t < 3; t++) expect_post(t, 0, "R5 ch0 after ch2");
    ack_pulse(3'b111);
    wait_settled(0);
    wait_settled(1);
    wait_settled(2);
    rx_need = '0;
    tx_need = '0;
    mdm_need = '0;
    ack_pulse(3'b111);
    repeat (3 * NCH) @(negedge clk);

    check(req == '0, "R4 all idle at end", int'(req), 0);
    check(exp_q[0].size() + exp_q[1].size() + exp_q[2].size() == 0,
          "R2 all expected posts seen",
          exp_q[0].size() + exp_q[1].size() + exp_q[2].size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule